// File: doc/BRIEF.md
# Two-Wire Slave Start Detector and Clock Stretcher

This block is the slave-side bus control for a two-wire serial bus in which an open-drain clock line and data line are pulled high when nobody pulls them low. It follows the bus from the system clock domain. It recognises a start condition and raises a start flag. After a start it holds the clock line low on the master's next falling clock edge. It counts every clock edge and holds the clock line low again when that count wraps. Software releases each hold by clearing the matching flag. A data register shifts the data line in on rising clock edges and presents its top bit on the data line, changing it on falling clock edges. The block also reports a stop condition, which never causes a hold.

The bus itself is the stream here. Holding the clock line low is the only back-pressure: while a hold flag is set, the master cannot produce another clock edge. Software loads the data register and the edge counter through write strobes. It reads both back directly, and clears each flag with a one-cycle strobe. Both line outputs only pull low or release, and never drive high. Both line inputs pass through synchronizers with no filtering. A master must therefore let the data line fall at least one system-clock sample before it lets the clock fall.

Top module: `tw_slave_ctrl`

## Requirements
- R1: After reset both pull outputs are 0, all three flags are 0, the edge count is 0 and the data register is 0.
- R2: A start flag is set when the synchronized data line falls while the synchronized clock line is high both on the sample before and on the sample of that fall. A data fall seen in the same sample as a clock fall sets no flag.
- R3: With the start flag set, the first falling clock edge afterwards makes `scl_pull_o` 1. The pull stays on until `start_clr` clears the flag. Without a start flag or an overflow flag, `scl_pull_o` is 0.
- R4: The edge count rises by one on every rising and every falling clock edge, so k bits give a count of 2k. A `cnt_wr` strobe loads `cnt_wdata` and takes priority over counting.
- R5: When the count wraps from 15 to 0, `ovf_flag` is set and `scl_pull_o` is 1 while the flag stays set. `ovf_clr` clears the flag and releases the pull.
- R6: Loading the count with 14 makes a single bit (two edges) wrap it, so a one-bit acknowledge phase ends in a hold.
- R7: On each rising clock edge the data register shifts left by one, and the data line value enters bit 0. After eight bits the register holds the byte sent by the master, with its first bit in bit 7.
- R8: `sda_pull_o` is 1 only when `sda_out_en` is 1 and the output bit is 0. The output bit takes bit 7 of the written value on a `dr_wr` strobe, and takes bit 7 of the data register on each falling clock edge, so a loaded byte appears first bit first.
- R9: A stop flag is set when the data line rises while the clock line is high. A stop causes no hold and is cleared by `stop_clr`.
- R10: Data line changes while the clock line is low set neither the start flag nor the stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_pull_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| sda_out_en | input | 1 | Lets the output bit drive the data line |
| dr_wr | input | 1 | Load strobe for the data register |
| dr_wdata | input | DATA_W | Value for the data register |
| dr_q | output | DATA_W | Data register contents |
| cnt_wr | input | 1 | Load strobe for the edge counter |
| cnt_wdata | input | CNT_W | Value for the edge counter |
| cnt_q | output | CNT_W | Edge counter value |
| start_clr | input | 1 | Clears the start flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| stop_clr | input | 1 | Clears the stop flag |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Edge counter wrapped |
| stop_flag | output | 1 | Stop condition seen |

## Verification
A bit-banged master writes random address bytes after each start. This separates correct left-shift sampling on rising edges from any off-by-one in shifting. Transfers are stopped after a random number of bits, so the count check can tell counting both edges from counting bits only. A slave-transmit byte behind a preset-14 acknowledge shows whether the output bit moves on falling edges and whether the short phase wraps into a hold. Directed patterns drop both lines in the same sample and toggle data while the clock is low, which separates true conditions from data changes in the low phase.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } tw_evt_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cur,
  output logic prev
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
    end
  end

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= cur;
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
  import tw_pkg::*;
(
  input  logic    sda_cur,
  input  logic    sda_prev,
  input  logic    scl_cur,
  input  logic    scl_prev,
  output tw_evt_t evt
);
  logic scl_high_both;

  assign scl_high_both = scl_prev & scl_cur;

  always_comb begin
    evt.scl_rise = ~scl_prev & scl_cur;
    evt.scl_fall = scl_prev & ~scl_cur;
    evt.start    = scl_high_both & sda_prev & ~sda_cur;
    evt.stop     = scl_high_both & ~sda_prev & sda_cur;
  end
endmodule

// File: rtl/tw_edge_counter.sv
module tw_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_ev,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign wrap = edge_ev & ~wr & (q == TOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       q <= '0;
    else if (wr)      q <= wdata;
    else if (edge_ev) q <= q + 1'b1;
endmodule

// File: rtl/tw_shift_reg.sv
module tw_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              out_bit
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q       <= '0;
      out_bit <= 1'b1;
    end else if (wr) begin
      q       <= wdata;
      out_bit <= wdata[DATA_W-1];
    end else begin
      if (scl_rise) q <= {q[DATA_W-2:0], sda_in};
      if (scl_fall) out_bit <= q[DATA_W-1];
    end
endmodule

// File: rtl/tw_hold_ctrl.sv
module tw_hold_ctrl
  import tw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tw_evt_t evt,
  input  logic    wrap,
  input  logic    start_clr,
  input  logic    ovf_clr,
  input  logic    stop_clr,
  output logic    start_flag,
  output logic    ovf_flag,
  output logic    stop_flag,
  output logic    scl_pull
);
  logic start_low_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_flag     <= 1'b0;
      start_low_seen <= 1'b0;
    end else if (evt.start) begin
      start_flag     <= 1'b1;
      start_low_seen <= 1'b0;
    end else if (start_clr) begin
      start_flag     <= 1'b0;
      start_low_seen <= 1'b0;
    end else if (start_flag && evt.scl_fall) begin
      start_low_seen <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        stop_flag <= 1'b0;
    else if (evt.stop) stop_flag <= 1'b1;
    else if (stop_clr) stop_flag <= 1'b0;

  assign scl_pull = start_low_seen | ovf_flag;
endmodule

// File: rtl/tw_slave_ctrl.sv
module tw_slave_ctrl
  import tw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              sda_out_en,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wdata,
  output logic [DATA_W-1:0] dr_q,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  input  logic              start_clr,
  input  logic              ovf_clr,
  input  logic              stop_clr,
  output logic              start_flag,
  output logic              ovf_flag,
  output logic              stop_flag
);
  logic    sda_cur, sda_prev, scl_cur, scl_prev;
  logic    wrap, out_bit;
  tw_evt_t evt;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .cur(sda_cur), .prev(sda_prev));

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .cur(scl_cur), .prev(scl_prev));

  tw_cond_detect u_cond (
    .sda_cur(sda_cur), .sda_prev(sda_prev),
    .scl_cur(scl_cur), .scl_prev(scl_prev), .evt(evt));

  tw_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .edge_ev(evt.scl_rise | evt.scl_fall),
    .wr(cnt_wr), .wdata(cnt_wdata), .q(cnt_q), .wrap(wrap));

  tw_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .scl_rise(evt.scl_rise), .scl_fall(evt.scl_fall),
    .sda_in(sda_cur), .wr(dr_wr), .wdata(dr_wdata), .q(dr_q), .out_bit(out_bit));

  tw_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wrap(wrap),
    .start_clr(start_clr), .ovf_clr(ovf_clr), .stop_clr(stop_clr),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
    .scl_pull(scl_pull_o));

  assign sda_pull_o = sda_out_en & ~out_bit;
endmodule

// File: rtl/tw_slave_ctrl_chk.sv
module tw_slave_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_cur,
  input logic              sda_prev,
  input logic              scl_cur,
  input logic              scl_prev,
  input logic              dr_wr,
  input logic              cnt_wr,
  input logic              sda_out_en,
  input logic [DATA_W-1:0] dr_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              start_flag,
  input logic              ovf_flag,
  input logic              stop_flag,
  input logic              scl_pull_o,
  input logic              sda_pull_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_start_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_prev && scl_cur && sda_prev && !sda_cur) |=> start_flag);

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_flag && !ovf_flag) |-> !scl_pull_o);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_prev != scl_cur) && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_count_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_prev == scl_cur) && !cnt_wr) |=> $stable(cnt_q));

  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_prev != scl_cur) && !cnt_wr && cnt_q == TOP) |=> ovf_flag);

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> scl_pull_o);

  p_shift_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_prev && scl_cur && !dr_wr) |=>
      dr_q == {$past(dr_q[DATA_W-2:0]), $past(sda_cur)});

  p_sda_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_out_en |-> !sda_pull_o);

  p_stop_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_prev && scl_cur && !sda_prev && sda_cur) |=> stop_flag);
endmodule

bind tw_slave_ctrl tw_slave_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sda_cur(sda_cur), .sda_prev(sda_prev), .scl_cur(scl_cur), .scl_prev(scl_prev),
  .dr_wr(dr_wr), .cnt_wr(cnt_wr), .sda_out_en(sda_out_en),
  .dr_q(dr_q), .cnt_q(cnt_q),
  .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
  .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o));

// File: tb/tw_slave_ctrl_test.sv
module tw_slave_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       sda_out_en = 1'b0, dr_wr = 1'b0, cnt_wr = 1'b0;
  logic [7:0] dr_wdata = '0;
  logic [3:0] cnt_wdata = '0;
  logic       start_clr = 1'b0, ovf_clr = 1'b0, stop_clr = 1'b0;
  logic       scl_pull_o, sda_pull_o, start_flag, ovf_flag, stop_flag;
  logic [7:0] dr_q;
  logic [3:0] cnt_q;
  wire        scl_bus = ~(m_scl_low | scl_pull_o);
  wire        sda_bus = ~(m_sda_low | sda_pull_o);

  int errors = 0, checks = 0;
  bit done = 1'b0;

  tw_slave_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .sda_out_en(sda_out_en),
    .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_q(dr_q),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .start_clr(start_clr), .ovf_clr(ovf_clr), .stop_clr(stop_clr),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag));

  function automatic logic [3:0] exp_cnt(input logic [3:0] preset, input int edges);
    return 4'(int'(preset) + edges);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start_clr(); start_clr = 1'b1; tick(1); start_clr = 1'b0; endtask
  task automatic pulse_ovf_clr();   ovf_clr = 1'b1;   tick(1); ovf_clr = 1'b0;   endtask
  task automatic pulse_stop_clr();  stop_clr = 1'b1;  tick(1); stop_clr = 1'b0;  endtask
  task automatic load_cnt(input logic [3:0] v);
    cnt_wdata = v; cnt_wr = 1'b1; tick(1); cnt_wr = 1'b0;
  endtask
  task automatic load_dr(input logic [7:0] v);
    dr_wdata = v; dr_wr = 1'b1; tick(1); dr_wr = 1'b0;
  endtask

  task automatic wait_scl_high();
    int n = 0;
    while (!scl_bus && n < 200) begin tick(1); n++; end
    if (!scl_bus) begin
      errors++; checks++;
      $display("FAIL R3: clock still held actual=0 expected=1");
    end
  endtask

  // one bit clocked by the master; returns the data line seen at high clock
  task automatic master_bit(input bit b, output bit rd);
    m_sda_low = ~b;
    tick(4);
    m_scl_low = 1'b0;
    wait_scl_high();
    tick(6);
    rd = sda_bus;
    m_scl_low = 1'b1;
    tick(6);
  endtask

  task automatic do_start();
    m_sda_low = 1'b0; tick(4);
    m_scl_low = 1'b0; wait_scl_high(); tick(4);
    m_sda_low = 1'b1; tick(8);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    bit rd;
    logic [7:0] b, got;
    void'($urandom(32'h1c2d));
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 scl_pull", scl_pull_o, 0);
    chk("R1 sda_pull", sda_pull_o, 0);
    chk("R1 flags", {start_flag, ovf_flag, stop_flag}, 0);
    chk("R1 count", cnt_q, 0);
    chk("R1 data", dr_q, 0);

    // R2 negative: both lines fall in the same sample
    m_sda_low = 1'b1; m_scl_low = 1'b1; tick(8);
    chk("R2 same-sample fall", start_flag, 0);
    chk("R3 no hold without flag", scl_pull_o, 0);
    m_scl_low = 1'b0; tick(8); m_sda_low = 1'b0; tick(8);
    chk("R9 stop after release", stop_flag, 1);
    pulse_stop_clr(); tick(2);

    for (int r = 0; r < 6; r++) begin
      int k;
      b = 8'($urandom);
      k = 1 + int'($urandom % 7);
      do_start();
      chk("R2 start flag", start_flag, 1);
      chk("R3 no hold before fall", scl_pull_o, 0);
      m_scl_low = 1'b1; tick(8);
      chk("R3 hold after fall", scl_pull_o, 1);
      m_sda_low = ~b[7]; m_scl_low = 1'b0; tick(8);
      chk("R3 line stretched", scl_bus, 0);
      load_cnt(4'd0);
      pulse_start_clr();
      tick(1);
      chk("R3 start cleared", start_flag, 0);
      for (int i = 7; i >= 0; i--) begin
        master_bit(b[i], rd);
        if (8 - i == k) begin
          chk("R4 partial count", cnt_q, exp_cnt(4'd0, 2 * k));
          chk("R5 no early wrap", ovf_flag, 0);
        end
      end
      chk("R5 wrap flag", ovf_flag, 1);
      chk("R5 wrap hold", scl_pull_o, 1);
      chk("R4 count after byte", cnt_q, exp_cnt(4'd0, 16));
      chk("R7 received byte", dr_q, b);
      if (r == 5) begin
        // R6 acknowledge phase with preset 14, then slave transmit
        load_dr(8'h00);
        sda_out_en = 1'b1;
        load_cnt(4'd14);
        pulse_ovf_clr();
        tick(4);
        chk("R5 release after clear", scl_pull_o, 0);
        master_bit(1'b1, rd);
        chk("R8 ack driven low", rd, 0);
        chk("R6 wrap after one bit", ovf_flag, 1);
        chk("R6 hold after ack", scl_pull_o, 1);
        b = 8'($urandom);
        load_dr(b);
        load_cnt(4'd0);
        pulse_ovf_clr();
        got = '0;
        for (int i = 7; i >= 0; i--) begin
          master_bit(1'b1, rd);
          got[i] = rd;
        end
        chk("R8 transmitted byte", got, b);
        chk("R7 register after loopback", dr_q, b);
        sda_out_en = 1'b0; tick(2);
        chk("R8 drive off", sda_pull_o, 0);
      end
      pulse_ovf_clr(); tick(4);
      chk("R5 released", scl_pull_o, 0);
    end

    // R9 stop: data rises while clock is high
    m_sda_low = 1'b1; tick(4);
    m_scl_low = 1'b0; wait_scl_high(); tick(4);
    m_sda_low = 1'b0; tick(8);
    chk("R9 stop flag", stop_flag, 1);
    chk("R9 no hold", scl_pull_o, 0);
    chk("R9 start untouched", start_flag, 0);
    pulse_stop_clr(); tick(2);
    chk("R9 stop cleared", stop_flag, 0);

    // R10 data toggles with the clock low
    m_scl_low = 1'b1; tick(6);
    for (int i = 0; i < 6; i++) begin
      m_sda_low = 1'($urandom); tick(5);
      m_sda_low = ~m_sda_low; tick(5);
    end
    chk("R10 no start", start_flag, 0);
    chk("R10 no stop", stop_flag, 0);
    chk("R10 no hold", scl_pull_o, 0);
    m_sda_low = 1'b0; tick(4); m_scl_low = 1'b0; tick(8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule